// File: doc/BRIEF.md
# Shared-Bus Register and Memory Transfer Fabric

This block moves words between four general registers over one shared bus and moves words between a small memory and a buffer register through a pointer register. In each cycle a 2-bit source code places one general register on the bus. A decoded destination code, gated by an enable, picks the general register that captures the bus value at the next rising clock edge. A register-to-register transfer therefore completes in one cycle. The bus is built as a per-bit four-way multiplexer, so no line is ever driven by more than one source.

The memory is reached only through two registers. The pointer register supplies the address and is loaded from an external pin. The buffer register is the only data path: a read copies the addressed word into it, and a write stores its contents at the addressed word. The buffer register can also be loaded from an external data pin or from the bus, and any general register can take the buffer value in place of the bus value. That gives a complete route between the general registers and the memory.

Every operation completes in the cycle it is requested. No input can be refused, so the block has no valid/ready handshake: the control pins are plain strobes and back-pressure does not arise. Asking for a read and a write at the same time is illegal. The block flags it and performs neither.

Top module: `xfer_fabric`

## Requirements
- R1: A synchronous reset, sampled high at a rising edge, clears all four general registers, the pointer register and the buffer register to zero. Memory contents are not cleared.
- R2: `bus_o` always equals the general register chosen by `src_sel`, with no clock delay. Code 00 picks lane 0, 01 picks lane 1, 10 picks lane 2 and 11 picks lane 3. Lane i occupies bits [8i+7:8i] of `gpr_o`.
- R3: When `dst_en` is 1 and `gpr_from_mbuf` is 0, the general register chosen by `dst_sel` (same code as R2) holds, after the next rising edge, the `bus_o` value from before that edge. The other three registers keep their values.
- R4: When `dst_en` is 0, no general register changes at the edge, whatever the value of `dst_sel`.
- R5: A transfer whose source and destination are the same register leaves that register unchanged.
- R6: When `ptr_ld` is 1, the pointer register takes `ptr_din` at the edge. Otherwise it holds its value.
- R7: A read alone (`mem_rd`=1, `mem_wr`=0) loads the buffer register with the memory word addressed by the pointer value from before the edge.
- R8: A write alone (`mem_wr`=1, `mem_rd`=0) stores the buffer value from before the edge at the address held by the pointer before the edge. A later read of that address returns it.
- R9: When `mem_rd` and `mem_wr` are both 1, `rw_err` is 1 in that cycle, the buffer register does not change (even if another load of it is requested), and no memory word changes.
- R10: The buffer register takes its new value by priority: a lone read first, then the external load (`mbuf_ext_ld`, value `mbuf_ext_din`), then the bus load (`mbuf_ld`, value `bus_o`). With none of these requested, it holds.
- R11: When `dst_en` and `gpr_from_mbuf` are both 1, the chosen general register loads the buffer value from before the edge instead of the bus value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_sel | input | 2 | Lane that drives the bus |
| dst_sel | input | 2 | Lane that loads at the edge |
| dst_en | input | 1 | Enable of the destination decoder |
| gpr_from_mbuf | input | 1 | Destination loads the buffer value instead of the bus |
| mbuf_ld | input | 1 | Buffer register loads the bus value |
| mbuf_ext_ld | input | 1 | Buffer register loads `mbuf_ext_din` |
| mbuf_ext_din | input | 8 | External data for the buffer register |
| mem_rd | input | 1 | Memory read into the buffer register |
| mem_wr | input | 1 | Memory write from the buffer register |
| ptr_ld | input | 1 | Pointer register loads `ptr_din` |
| ptr_din | input | 4 | External address for the pointer register |
| bus_o | output | 8 | Current bus value |
| gpr_o | output | 32 | The four general registers, lane 0 in the low byte |
| ptr_o | output | 4 | Pointer register |
| mbuf_o | output | 8 | Buffer register |
| rw_err | output | 1 | Read and write were requested together |

## Verification
The assertions assume that the select and strobe inputs are 0 or 1 at every sampled edge and that reset is asserted from time zero. They make no assumption that reads and writes are exclusive, since the conflict case is itself a property. The random stimulus always drives known values, inserts read/write conflicts on purpose, and issues a lone read only at an address that has already been written. As a result, every value the buffer register can take is known to the bench.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int LANES = 4;
  localparam int SEL_W = $clog2(LANES);
  typedef logic [SEL_W-1:0] lane_idx_t;
endpackage

// File: rtl/bus_mux.sv
module bus_mux import xfer_pkg::*; #(
  parameter int W = 8
) (
  input  logic [LANES*W-1:0] lanes_i,
  input  lane_idx_t          sel_i,
  output logic [W-1:0]       bus_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [LANES-1:0] column;
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign column[l] = lanes_i[l*W + b];
    end
    assign bus_o[b] = column[sel_i];
  end
endmodule

// File: rtl/dst_decoder.sv
module dst_decoder import xfer_pkg::*; (
  input  lane_idx_t        code_i,
  input  logic             en_i,
  output logic [LANES-1:0] hot_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_out
    assign hot_o[i] = en_i && (code_i == SEL_W'(i));
  end
endmodule

// File: rtl/word_store.sv
module word_store #(
  parameter int W  = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[addr_i] <= wdata_i;
  end

  assign rdata_o = cells[addr_i];
endmodule

// File: rtl/xfer_fabric.sv
module xfer_fabric import xfer_pkg::*; #(
  parameter int N = 8,
  parameter int K = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         src_sel,
  input  logic [1:0]         dst_sel,
  input  logic               dst_en,
  input  logic               gpr_from_mbuf,
  input  logic               mbuf_ld,
  input  logic               mbuf_ext_ld,
  input  logic [N-1:0]       mbuf_ext_din,
  input  logic               mem_rd,
  input  logic               mem_wr,
  input  logic               ptr_ld,
  input  logic [K-1:0]       ptr_din,
  output logic [N-1:0]       bus_o,
  output logic [LANES*N-1:0] gpr_o,
  output logic [K-1:0]       ptr_o,
  output logic [N-1:0]       mbuf_o,
  output logic               rw_err
);
  logic [LANES*N-1:0] lanes;
  logic [LANES-1:0]   hot;
  logic [N-1:0]       bus, rdata, load_val, mbuf_q;
  logic [K-1:0]       ptr_q;
  logic               conflict, rd_go, wr_go;

  assign conflict = mem_rd & mem_wr;
  assign rd_go    = mem_rd & ~mem_wr;
  assign wr_go    = mem_wr & ~mem_rd & ~rst;

  bus_mux #(.W(N)) u_bus (
    .lanes_i (lanes),
    .sel_i   (src_sel),
    .bus_o   (bus)
  );

  dst_decoder u_dec (
    .code_i (dst_sel),
    .en_i   (dst_en),
    .hot_o  (hot)
  );

  assign load_val = gpr_from_mbuf ? mbuf_q : bus;

  for (genvar g = 0; g < LANES; g++) begin : g_gpr
    logic [N-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)         q <= '0;
      else if (hot[g]) q <= load_val;
    end
    assign lanes[g*N +: N] = q;
  end

  always_ff @(posedge clk) begin
    if (rst)         ptr_q <= '0;
    else if (ptr_ld) ptr_q <= ptr_din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mbuf_q <= '0;
    end else if (!conflict) begin
      if (rd_go)            mbuf_q <= rdata;
      else if (mbuf_ext_ld) mbuf_q <= mbuf_ext_din;
      else if (mbuf_ld)     mbuf_q <= bus;
    end
  end

  word_store #(.W(N), .AW(K)) u_mem (
    .clk     (clk),
    .wr_en   (wr_go),
    .addr_i  (ptr_q),
    .wdata_i (mbuf_q),
    .rdata_o (rdata)
  );

  assign bus_o  = bus;
  assign gpr_o  = lanes;
  assign ptr_o  = ptr_q;
  assign mbuf_o = mbuf_q;
  assign rw_err = conflict;
endmodule

// File: rtl/xfer_fabric_chk.sv
module xfer_fabric_chk #(
  parameter int N = 8,
  parameter int K = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [1:0]     src_sel,
  input logic [1:0]     dst_sel,
  input logic           dst_en,
  input logic           gpr_from_mbuf,
  input logic           mem_rd,
  input logic           mem_wr,
  input logic           ptr_ld,
  input logic [K-1:0]   ptr_din,
  input logic [N-1:0]   bus_o,
  input logic [4*N-1:0] gpr_o,
  input logic [K-1:0]   ptr_o,
  input logic [N-1:0]   mbuf_o
);
  function automatic logic [N-1:0] lane(input logic [4*N-1:0] v, input logic [1:0] i);
    return v[i*N +: N];
  endfunction

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (gpr_o == '0 && ptr_o == '0 && mbuf_o == '0));

  // R2
  bus_pick_chk: assert property (@(posedge clk) disable iff (rst)
    bus_o == lane(gpr_o, src_sel));

  // R3
  dst_load_chk: assert property (@(posedge clk) disable iff (rst)
    (dst_en && !gpr_from_mbuf) |=> lane(gpr_o, $past(dst_sel)) == $past(bus_o));

  // R11
  mbuf_route_chk: assert property (@(posedge clk) disable iff (rst)
    (dst_en && gpr_from_mbuf) |=> lane(gpr_o, $past(dst_sel)) == $past(mbuf_o));

  // R4
  no_load_chk: assert property (@(posedge clk) disable iff (rst)
    !dst_en |=> $stable(gpr_o));

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ptr_ld |=> $stable(ptr_o));

  // R6
  ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
    ptr_ld |=> ptr_o == $past(ptr_din));

  // R9
  conflict_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && mem_wr) |=> $stable(mbuf_o));
endmodule

bind xfer_fabric xfer_fabric_chk #(.N(N), .K(K)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .src_sel       (src_sel),
  .dst_sel       (dst_sel),
  .dst_en        (dst_en),
  .gpr_from_mbuf (gpr_from_mbuf),
  .mem_rd        (mem_rd),
  .mem_wr        (mem_wr),
  .ptr_ld        (ptr_ld),
  .ptr_din       (ptr_din),
  .bus_o         (bus_o),
  .gpr_o         (gpr_o),
  .ptr_o         (ptr_o),
  .mbuf_o        (mbuf_o)
);

// File: tb/xfer_fabric_tb.sv
`timescale 1ns/1ps
module xfer_fabric_tb;
  logic clk = 1'b0;
  logic rst;
  logic [1:0] src_sel, dst_sel;
  logic dst_en, gpr_from_mbuf, mbuf_ld, mbuf_ext_ld, mem_rd, mem_wr, ptr_ld;
  logic [7:0] mbuf_ext_din;
  logic [3:0] ptr_din;
  logic [7:0] bus_o, mbuf_o;
  logic [31:0] gpr_o;
  logic [3:0] ptr_o;
  logic rw_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m_gpr [4];
  logic [7:0] m_mbuf;
  logic [3:0] m_ptr;
  logic [7:0] m_mem [16];
  bit         m_known [16];

  always #5 clk = ~clk;

  xfer_fabric u_dut (
    .clk(clk), .rst(rst), .src_sel(src_sel), .dst_sel(dst_sel), .dst_en(dst_en),
    .gpr_from_mbuf(gpr_from_mbuf), .mbuf_ld(mbuf_ld), .mbuf_ext_ld(mbuf_ext_ld),
    .mbuf_ext_din(mbuf_ext_din), .mem_rd(mem_rd), .mem_wr(mem_wr), .ptr_ld(ptr_ld),
    .ptr_din(ptr_din), .bus_o(bus_o), .gpr_o(gpr_o), .ptr_o(ptr_o), .mbuf_o(mbuf_o),
    .rw_err(rw_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    rst = 0; src_sel = 0; dst_sel = 0; dst_en = 0; gpr_from_mbuf = 0; mbuf_ld = 0;
    mbuf_ext_ld = 0; mbuf_ext_din = 0; mem_rd = 0; mem_wr = 0; ptr_ld = 0; ptr_din = 0;
  endtask

  // Inputs are already driven (after a falling edge); one full cycle follows.
  task automatic step();
    logic [7:0] bus_e, load_e, mbuf_n;
    #1;
    bus_e = m_gpr[src_sel];
    if (!rst) begin
      chk(bus_o == bus_e, "R2 bus source", bus_o, bus_e);
      chk(rw_err == (mem_rd && mem_wr), "R9 conflict flag", rw_err, mem_rd && mem_wr);
    end
    load_e = gpr_from_mbuf ? m_mbuf : bus_e;
    mbuf_n = m_mbuf;
    if (!(mem_rd && mem_wr)) begin
      if (mem_rd)           mbuf_n = m_mem[m_ptr];
      else if (mbuf_ext_ld) mbuf_n = mbuf_ext_din;
      else if (mbuf_ld)     mbuf_n = bus_e;
    end
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < 4; i++) m_gpr[i] = 0;
      m_ptr = 0;
      m_mbuf = 0;
    end else begin
      if (mem_wr && !mem_rd) begin
        m_mem[m_ptr] = m_mbuf;
        m_known[m_ptr] = 1;
      end
      if (dst_en) m_gpr[dst_sel] = load_e;
      if (ptr_ld) m_ptr = ptr_din;
      m_mbuf = mbuf_n;
    end
    @(negedge clk);
    for (int i = 0; i < 4; i++)
      chk(gpr_o[i*8 +: 8] == m_gpr[i], "R1/R3/R4/R5/R11 lane", gpr_o[i*8 +: 8], m_gpr[i]);
    chk(ptr_o == m_ptr, "R1/R6 pointer", ptr_o, m_ptr);
    chk(mbuf_o == m_mbuf, "R1/R7/R9/R10 buffer", mbuf_o, m_mbuf);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    for (int i = 0; i < 16; i++) begin m_mem[i] = 0; m_known[i] = 0; end
    for (int i = 0; i < 4; i++) m_gpr[i] = 8'hxx;
    idle();
    rst = 1;
    @(negedge clk);
    // R1: reset clears state
    step(); step();
    chk(gpr_o == 32'h0 && ptr_o == 0 && mbuf_o == 0, "R1 reset state", gpr_o, 0);
    idle();

    // R10: external load of buffer
    mbuf_ext_ld = 1; mbuf_ext_din = 8'h5A; step(); idle();
    // R11: lane 2 loads buffer instead of bus
    dst_en = 1; dst_sel = 2; gpr_from_mbuf = 1; src_sel = 0; step(); idle();
    chk(gpr_o[23:16] == 8'h5A, "R11 route", gpr_o[23:16], 8'h5A);
    mbuf_ext_ld = 1; mbuf_ext_din = 8'h3C; step(); idle();
    dst_en = 1; dst_sel = 1; gpr_from_mbuf = 1; step(); idle();
    // R3: lane 2 -> lane 0 over the bus
    src_sel = 2; dst_sel = 0; dst_en = 1; step(); idle();
    chk(gpr_o[7:0] == 8'h5A, "R3 bus transfer", gpr_o[7:0], 8'h5A);
    // R5: self transfer
    src_sel = 1; dst_sel = 1; dst_en = 1; step(); idle();
    chk(gpr_o[15:8] == 8'h3C, "R5 self transfer", gpr_o[15:8], 8'h3C);
    // R4: decoder disabled
    src_sel = 2; dst_sel = 3; dst_en = 0; step(); idle();
    chk(gpr_o[31:24] == 8'h00, "R4 disabled decode", gpr_o[31:24], 8'h00);
    // R6: pointer load
    ptr_ld = 1; ptr_din = 4'd7; step(); idle();
    // R10: buffer from bus (lane 1)
    src_sel = 1; mbuf_ld = 1; step(); idle();
    // R8: write to address 7
    mem_wr = 1; step(); idle();
    mbuf_ext_ld = 1; mbuf_ext_din = 8'h00; step(); idle();
    // R7: read back address 7
    mem_rd = 1; step(); idle();
    chk(mbuf_o == 8'h3C, "R7/R8 read back", mbuf_o, 8'h3C);
    // R9: conflict with an external load pending
    mbuf_ext_ld = 1; mbuf_ext_din = 8'hEE; mem_rd = 1; mem_wr = 1; step(); idle();
    chk(mbuf_o == 8'h3C, "R9 buffer held", mbuf_o, 8'h3C);
    mbuf_ext_ld = 1; mbuf_ext_din = 8'h77; step(); idle();
    // R10: read has priority over external load; R9: memory untouched
    mem_rd = 1; mbuf_ext_ld = 1; mbuf_ext_din = 8'h99; step(); idle();
    chk(mbuf_o == 8'h3C, "R9/R10 priority and memory kept", mbuf_o, 8'h3C);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      idle();
      src_sel = 2'($urandom_range(3));
      dst_sel = 2'($urandom_range(3));
      dst_en = ($urandom_range(3) != 0);
      gpr_from_mbuf = ($urandom_range(3) == 0);
      mbuf_ld = ($urandom_range(3) == 0);
      mbuf_ext_ld = ($urandom_range(3) == 0);
      mbuf_ext_din = 8'($urandom);
      ptr_ld = ($urandom_range(3) == 0);
      ptr_din = 4'($urandom);
      mem_wr = ($urandom_range(3) == 0);
      mem_rd = m_known[m_ptr] && !mem_wr && ($urandom_range(2) == 0);
      if ($urandom_range(19) == 0) begin mem_rd = 1; mem_wr = 1; end
      step();
    end

    // R1: reset in mid run
    idle(); rst = 1; mem_wr = 1; step(); idle();
    chk(gpr_o == 32'h0 && ptr_o == 0 && mbuf_o == 0, "R1 reset mid run", gpr_o, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule